// File: doc/BRIEF.md
# Variable-Depth Sum-of-Products Array

This block is the programmable logic plane of a small registered-logic device. Twenty-two input signals feed 44 array columns, with column 2i carrying signal i and column 2i+1 carrying its complement. Each of 132 product-term rows ANDs the columns whose fuse is connected. Ten outputs each get one enable term and a block of logic terms whose depth rises from the two outer outputs toward the middle pair. The array also produces one global clear term, one global set term and twenty macrocell mode bits, which it passes on to macrocell logic outside the block.

Configuration arrives over a serial port. A start strobe erases every fuse and resets the load address to zero. Each cycle with the shift enable high then writes one bit at the current address and advances it. The fuse image covers the array, then the mode bits, then a 64-bit user signature that may be left out of the stream. A readback port returns any fuse one cycle after its address is presented. Once software raises the lock request, readback hides the array and mode bits but still shows the signature. Only another start strobe or a reset clears the lock.

Top module: `sop_array`

## Requirements
- R1: A product term is the AND of every column whose fuse bit is 0 (connected); a fuse bit of 1 removes that column. Column 2i is sig_in[i] and column 2i+1 is its inverse, so a row with all fuses 0 gives 0 and a row with all fuses 1 gives 1.
- R2: Row 0 drives ar_term and row 131 drives sp_term. Output k occupies a contiguous block: its enable row comes first, followed by its logic rows. The blocks start at row 1 in output order, with logic depths 8, 10, 12, 14, 16, 16, 14, 12, 10, 8 (output 3 enable row is 34, output 9 last logic row is 130).
- R3: sum_out[k] is the OR of output k's logic rows only and oe_out[k] is its enable row alone; the enable row never contributes to the sum.
- R4: Fuse (row, column) sits at load address row*44+column; the load address starts at 0 after the start strobe and advances by one on each cycle with shift_en high.
- R5: Addresses 5808+2k and 5809+2k hold the two mode bits of cell k and appear on cell_mode[2k] and cell_mode[2k+1].
- R6: Addresses 5828 to 5891 hold the signature, bit (address-5828), readable through the readback port.
- R7: prog_start erases every fuse, mode and signature bit to 0, clears the lock and returns the load address to 0.
- R8: load_done goes high after the 5828th shift following a start strobe; shifts after address 5891 are ignored.
- R9: rd_bit shows the bit at rd_addr one clock after it is presented; addresses at or above 5892 read as 0.
- R10: A lock_req pulse sets the lock; while it is set, addresses below 5828 read as 0 but signature addresses read normally; the lock stays set until prog_start or rst.
- R11: A stream of exactly 5828 bits after a start strobe configures the array and mode bits fully and leaves the signature at 0.
- R12: After rst every output is 0: sums, enables, both global terms, mode bits, load_done and rd_bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, erases the configuration |
| prog_start | input | 1 | Erase strobe and load address restart |
| shift_en | input | 1 | Write shift_bit at the load address and advance |
| shift_bit | input | 1 | Serial configuration data |
| lock_req | input | 1 | Pulse that sets the readback lock |
| rd_addr | input | 13 | Readback address |
| rd_bit | output | 1 | Readback data, one cycle after rd_addr |
| load_done | output | 1 | Core image (array and modes) fully shifted in |
| sig_in | input | 22 | Array input signals |
| sum_out | output | 10 | Per-output OR of logic terms |
| oe_out | output | 10 | Per-output enable term |
| ar_term | output | 1 | Global clear product term |
| sp_term | output | 1 | Global set product term |
| cell_mode | output | 20 | Two mode bits per macrocell |

## Verification
The sums, enables and global terms depend combinationally on sig_in and on the stored fuses. A change of sig_in shows in the same cycle, and a shifted fuse shows after the rising edge that accepts it. rd_bit and load_done are registered, so they are due one edge after rd_addr is presented or after the 5828th shift. The bench drives every input at the falling edge and updates its behavioural model at the rising edge. It then compares all outputs at the next falling edge, so each expected value is taken exactly one edge after the stimulus that produced it.

// File: rtl/sop_pkg.sv
package sop_pkg;

    localparam int N_SIG      = 22;
    localparam int N_COL      = 2 * N_SIG;
    localparam int N_OUT      = 10;
    localparam int MIN_TERMS  = 8;
    localparam int TERM_STEP  = 2;
    localparam int HALF       = N_OUT / 2;
    localparam int SIG_BITS   = 64;

    // logic depth of output k: mirrored around the middle pair
    function automatic int terms_of(input int k);
        int m;
        m = (k < HALF) ? k : (N_OUT - 1 - k);
        return MIN_TERMS + TERM_STEP * m;
    endfunction

    // first row of output k's block (its enable row); row 0 is the clear term
    function automatic int oe_row_of(input int k);
        int r;
        r = 1;
        for (int j = 0; j < k; j++) r += terms_of(j) + 1;
        return r;
    endfunction

    localparam int N_ROW       = oe_row_of(N_OUT) + 1;
    localparam int ARRAY_FUSES = N_ROW * N_COL;
    localparam int MODE_BITS   = 2 * N_OUT;
    localparam int CORE_FUSES  = ARRAY_FUSES + MODE_BITS;
    localparam int TOTAL_FUSES = CORE_FUSES + SIG_BITS;

    localparam int AW  = $clog2(TOTAL_FUSES + 1);
    localparam int RW  = $clog2(N_ROW + 1);
    localparam int CW  = $clog2(N_COL);
    localparam int MIW = $clog2(MODE_BITS);
    localparam int SIW = $clog2(SIG_BITS);

    typedef logic [N_COL-1:0] row_t;
    typedef logic [AW-1:0]    addr_t;

    localparam addr_t A_ARR   = addr_t'(ARRAY_FUSES);
    localparam addr_t A_CORE  = addr_t'(CORE_FUSES);
    localparam addr_t A_TOTAL = addr_t'(TOTAL_FUSES);
    localparam addr_t A_NCOL  = addr_t'(N_COL);

    typedef enum logic [1:0] {SEG_ARRAY, SEG_MODE, SEG_SIG, SEG_NONE} seg_e;

    typedef struct packed {
        logic [RW-1:0] row;
        logic [CW-1:0] col;
        addr_t         flat;
    } cursor_t;

    function automatic seg_e seg_of(input addr_t a);
        if (a < A_ARR)        return SEG_ARRAY;
        else if (a < A_CORE)  return SEG_MODE;
        else if (a < A_TOTAL) return SEG_SIG;
        else                  return SEG_NONE;
    endfunction

endpackage

// File: rtl/sop_fuse_store.sv
module sop_fuse_store
    import sop_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 prog_start,
    input  logic                 shift_en,
    input  logic                 shift_bit,
    input  logic                 lock_req,
    input  addr_t                rd_addr,
    output logic                 rd_bit,
    output logic                 load_done,
    output row_t [N_ROW-1:0]     fuse_rows,
    output logic [MODE_BITS-1:0] cell_mode
);

    row_t [N_ROW-1:0]     arr_q;
    logic [MODE_BITS-1:0] mode_q;
    logic [SIG_BITS-1:0]  sig_q;
    logic                 lock_q;
    cursor_t              cur_q;
    logic                 rd_q;
    logic                 rd_next;

    localparam logic [CW-1:0] C_LAST = CW'(N_COL - 1);

    logic [MIW-1:0] wr_midx, rd_midx;
    logic [SIW-1:0] wr_sidx, rd_sidx;
    logic [RW-1:0]  rd_row;
    logic [CW-1:0]  rd_col;

    assign wr_midx = MIW'(cur_q.flat - A_ARR);
    assign wr_sidx = SIW'(cur_q.flat - A_CORE);
    assign rd_midx = MIW'(rd_addr - A_ARR);
    assign rd_sidx = SIW'(rd_addr - A_CORE);
    assign rd_row  = RW'(rd_addr / A_NCOL);
    assign rd_col  = CW'(rd_addr % A_NCOL);

    // serial load: start strobe erases, each shift writes and advances
    always_ff @(posedge clk) begin
        if (rst || prog_start) begin
            arr_q  <= '0;
            mode_q <= '0;
            sig_q  <= '0;
            lock_q <= 1'b0;
            cur_q  <= '0;
        end else begin
            if (lock_req) lock_q <= 1'b1;
            if (shift_en && cur_q.flat < A_TOTAL) begin
                unique case (seg_of(cur_q.flat))
                    SEG_ARRAY: arr_q[cur_q.row][cur_q.col] <= shift_bit;
                    SEG_MODE:  mode_q[wr_midx] <= shift_bit;
                    SEG_SIG:   sig_q[wr_sidx]  <= shift_bit;
                    default:   ;
                endcase
                cur_q.flat <= cur_q.flat + 1'b1;
                if (cur_q.col == C_LAST) begin
                    cur_q.col <= '0;
                    cur_q.row <= cur_q.row + 1'b1;
                end else begin
                    cur_q.col <= cur_q.col + 1'b1;
                end
            end
        end
    end

    // readback: the lock hides array and mode bits, never the signature
    always_comb begin
        rd_next = 1'b0;
        unique case (seg_of(rd_addr))
            SEG_ARRAY: rd_next = arr_q[rd_row][rd_col] & ~lock_q;
            SEG_MODE:  rd_next = mode_q[rd_midx] & ~lock_q;
            SEG_SIG:   rd_next = sig_q[rd_sidx];
            default:   rd_next = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rd_q <= 1'b0;
        else     rd_q <= rd_next;
    end

    assign rd_bit    = rd_q;
    assign load_done = (cur_q.flat >= A_CORE);
    assign fuse_rows = arr_q;
    assign cell_mode = mode_q;

    // R10
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (lock_q && !prog_start) |=> lock_q);

    // R10
    lock_hides_chk: assert property (@(posedge clk) disable iff (rst)
        (lock_q && rd_addr < A_CORE) |=> !rd_bit);

    // R7
    start_clears_chk: assert property (@(posedge clk) disable iff (rst)
        prog_start |=> (cur_q.flat == '0 && !load_done && !lock_q));

    // R4
    addr_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !prog_start && cur_q.flat < A_TOTAL)
            |=> (cur_q.flat == addr_t'($past(cur_q.flat) + 1'b1)));

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q.flat == A_TOTAL && !prog_start) |=> $stable(cur_q.flat));

endmodule

// File: rtl/sop_pterm_plane.sv
module sop_pterm_plane
    import sop_pkg::*;
(
    input  logic [N_SIG-1:0] sig_in,
    input  row_t [N_ROW-1:0] fuse_rows,
    output logic [N_ROW-1:0] pterm
);

    row_t cols;

    for (genvar i = 0; i < N_SIG; i++) begin : g_col
        assign cols[2*i]     = sig_in[i];
        assign cols[2*i + 1] = ~sig_in[i];
    end

    // a set fuse bit lifts its column out of the AND
    for (genvar r = 0; r < N_ROW; r++) begin : g_row
        assign pterm[r] = &(fuse_rows[r] | cols);
    end

endmodule

// File: rtl/sop_sum_plane.sv
module sop_sum_plane
    import sop_pkg::*;
(
    input  logic [N_ROW-1:0] pterm,
    output logic [N_OUT-1:0] sum_out,
    output logic [N_OUT-1:0] oe_out,
    output logic             ar_term,
    output logic             sp_term
);

    for (genvar k = 0; k < N_OUT; k++) begin : g_cell
        localparam int OE_ROW = oe_row_of(k);
        localparam int DEPTH  = terms_of(k);
        assign oe_out[k]  = pterm[OE_ROW];
        assign sum_out[k] = |pterm[OE_ROW + 1 +: DEPTH];
    end

    assign ar_term = pterm[0];
    assign sp_term = pterm[N_ROW-1];

endmodule

// File: rtl/sop_array.sv
module sop_array
    import sop_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 prog_start,
    input  logic                 shift_en,
    input  logic                 shift_bit,
    input  logic                 lock_req,
    input  logic [AW-1:0]        rd_addr,
    output logic                 rd_bit,
    output logic                 load_done,
    input  logic [N_SIG-1:0]     sig_in,
    output logic [N_OUT-1:0]     sum_out,
    output logic [N_OUT-1:0]     oe_out,
    output logic                 ar_term,
    output logic                 sp_term,
    output logic [MODE_BITS-1:0] cell_mode
);

    row_t [N_ROW-1:0] fuse_rows;
    logic [N_ROW-1:0] pterm;

    sop_fuse_store u_store (
        .clk        (clk),
        .rst        (rst),
        .prog_start (prog_start),
        .shift_en   (shift_en),
        .shift_bit  (shift_bit),
        .lock_req   (lock_req),
        .rd_addr    (rd_addr),
        .rd_bit     (rd_bit),
        .load_done  (load_done),
        .fuse_rows  (fuse_rows),
        .cell_mode  (cell_mode)
    );

    sop_pterm_plane u_pterm (
        .sig_in    (sig_in),
        .fuse_rows (fuse_rows),
        .pterm     (pterm)
    );

    sop_sum_plane u_sum (
        .pterm   (pterm),
        .sum_out (sum_out),
        .oe_out  (oe_out),
        .ar_term (ar_term),
        .sp_term (sp_term)
    );

endmodule

// File: tb/sop_array_bench.sv
`timescale 1ns/1ps
module sop_array_bench;

    logic        clk = 1'b0;
    logic        rst, prog_start, shift_en, shift_bit, lock_req;
    logic [12:0] rd_addr;
    logic [21:0] sig_in;
    logic        rd_bit, load_done, ar_term, sp_term;
    logic [9:0]  sum_out, oe_out;
    logic [19:0] cell_mode;

    always #5 clk = ~clk;

    sop_array u_sop_array (
        .clk(clk), .rst(rst), .prog_start(prog_start), .shift_en(shift_en),
        .shift_bit(shift_bit), .lock_req(lock_req), .rd_addr(rd_addr),
        .rd_bit(rd_bit), .load_done(load_done), .sig_in(sig_in),
        .sum_out(sum_out), .oe_out(oe_out), .ar_term(ar_term),
        .sp_term(sp_term), .cell_mode(cell_mode)
    );

    int checks = 0;
    int errors = 0;

    localparam logic [19:0] MODE_PAT = 20'hA5C3F;
    localparam logic [63:0] SIG_PAT  = 64'h0123_4567_89AB_CDEF;

    // behavioural reference state
    bit m_fuse [5892];
    int m_cnt  = 0;
    bit m_lock = 0;
    bit m_rd   = 0;
    int depth_tab [10] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};
    bit img [5892];

    always @(posedge clk) begin
        if (rst)                m_rd = 1'b0;
        else if (rd_addr < 5828) m_rd = m_lock ? 1'b0 : m_fuse[rd_addr];
        else if (rd_addr < 5892) m_rd = m_fuse[rd_addr];
        else                     m_rd = 1'b0;
        if (rst || prog_start) begin
            foreach (m_fuse[i]) m_fuse[i] = 1'b0;
            m_cnt  = 0;
            m_lock = 1'b0;
        end else begin
            if (lock_req) m_lock = 1'b1;
            if (shift_en && m_cnt < 5892) begin
                m_fuse[m_cnt] = shift_bit;
                m_cnt++;
            end
        end
    end

    function automatic bit m_term(int r);
        for (int c = 0; c < 44; c++) begin
            bit lit;
            lit = (c % 2 == 0) ? sig_in[c/2] : !sig_in[c/2];
            if (!m_fuse[r*44 + c] && !lit) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [9:0]  e_sum, e_oe;
        logic [19:0] e_mode;
        int r;
        r = 1;
        for (int k = 0; k < 10; k++) begin
            e_oe[k] = m_term(r);
            r++;
            e_sum[k] = 1'b0;
            for (int t = 0; t < depth_tab[k]; t++) begin
                e_sum[k] = e_sum[k] | m_term(r);
                r++;
            end
        end
        for (int i = 0; i < 20; i++) e_mode[i] = m_fuse[5808 + i];
        check("R3 sum_out", sum_out, e_sum);
        check("R3 oe_out", oe_out, e_oe);
        check("R2 ar_term", ar_term, m_term(0));
        check("R2 sp_term", sp_term, m_term(131));
        check("R5 cell_mode", cell_mode, e_mode);
        check("R8 load_done", load_done, m_cnt >= 5828);
        check("R9 rd_bit", rd_bit, m_rd);
    endtask

    task automatic tick();
        @(negedge clk);
        compare_all();
    endtask

    task automatic start_erase();
        prog_start = 1'b1;
        tick();
        prog_start = 1'b0;
    endtask

    task automatic load(int count);
        start_erase();
        for (int i = 0; i < count; i++) begin
            shift_en  = 1'b1;
            shift_bit = img[i];
            tick();
            if (i == 5826) check("R8 done low before core end", load_done, 1'b0);
            if (i == 5827) check("R8 done high at core end", load_done, 1'b1);
        end
        shift_en = 1'b0;
        tick();
    endtask

    task automatic read_bit(int a, output logic v);
        rd_addr = 13'(a);
        tick();
        v = rd_bit;
    endtask

    // row r connects only column r%44; modes and signature from patterns
    task automatic build_diag();
        for (int r = 0; r < 132; r++)
            for (int c = 0; c < 44; c++)
                img[r*44 + c] = (c != r % 44);
        for (int i = 0; i < 20; i++) img[5808 + i] = MODE_PAT[i];
        for (int i = 0; i < 64; i++) img[5828 + i] = SIG_PAT[i];
    endtask

    // every row fully connected except rows 1, 34, 130, 131
    task automatic build_rows();
        foreach (img[i]) img[i] = 1'b0;
        for (int c = 0; c < 44; c++) begin
            img[1*44 + c]   = 1'b1;
            img[34*44 + c]  = 1'b1;
            img[130*44 + c] = 1'b1;
            img[131*44 + c] = 1'b1;
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog (all requirements) actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic       v;
        logic [63:0] sig_rd;
        rst = 1'b1; prog_start = 1'b0; shift_en = 1'b0; shift_bit = 1'b0;
        lock_req = 1'b0; rd_addr = '0; sig_in = '0;
        tick();
        tick();
        rst = 1'b0;
        tick();

        // R12 reset state
        check("R12 sum after reset", sum_out, 0);
        check("R12 oe after reset", oe_out, 0);
        check("R12 global terms after reset", {ar_term, sp_term}, 0);
        check("R12 mode after reset", cell_mode, 0);
        check("R12 done/rd after reset", {load_done, rd_bit}, 0);

        // full image with diagonal rows
        build_diag();
        load(5892);
        check("R5 mode bits after full load", cell_mode, MODE_PAT);

        sig_in = 22'h0;
        tick();
        check("R1 clear term with true column low", ar_term, 1'b0);
        check("R1 set term with complement column high", sp_term, 1'b1);
        sig_in = 22'h3F_FFFF;
        tick();
        check("R1 clear term with true column high", ar_term, 1'b1);
        check("R1 set term with complement column low", sp_term, 1'b0);
        for (int i = 0; i < 40; i++) begin
            sig_in = 22'((i + 1) * 32'h9E37_79B1 >> 5);
            tick();
        end

        // R4 address map through readback, before lock
        read_bit(44*5 + 7, v);
        check("R4 fuse row5 col7", v, 1'b1);
        read_bit(44*7 + 7, v);
        check("R4 fuse row7 col7", v, 1'b0);
        read_bit(6000, v);
        check("R9 out-of-range read", v, 1'b0);
        read_bit(5808 + 0, v);
        check("R9 mode bit read unlocked", v, MODE_PAT[0]);

        // R8 extra shifts after the end are ignored
        for (int i = 0; i < 5; i++) begin
            shift_en  = 1'b1;
            shift_bit = ~img[5891];
            tick();
        end
        shift_en = 1'b0;
        read_bit(5891, v);
        check("R8 last signature bit kept", v, img[5891]);

        // R10 lock hides array and mode, R6 signature readable
        lock_req = 1'b1;
        tick();
        lock_req = 1'b0;
        read_bit(44*5 + 7, v);
        check("R10 locked array read", v, 1'b0);
        read_bit(5808, v);
        check("R10 locked mode read", v, 1'b0);
        for (int i = 0; i < 64; i++) begin
            read_bit(5828 + i, v);
            sig_rd[i] = v;
        end
        check("R6 signature under lock", sig_rd, SIG_PAT);
        for (int i = 0; i < 4; i++) tick();
        read_bit(44*5 + 7, v);
        check("R10 lock stays set", v, 1'b0);

        // R7 erase
        start_erase();
        tick();
        check("R7 sum after erase", sum_out, 0);
        check("R7 oe after erase", oe_out, 0);
        check("R7 mode/done after erase", {cell_mode, load_done}, 0);
        read_bit(5808, v);
        check("R7 lock cleared, mode erased", v, 1'b0);

        // R11 core-only image
        build_diag();
        load(5828);
        check("R11 mode bits from core image", cell_mode, MODE_PAT);
        check("R11 done after core image", load_done, 1'b1);
        read_bit(5830, v);
        check("R11 signature bit left erased", v, 1'b0);
        read_bit(44*5 + 7, v);
        check("R11 array bit loaded", v, 1'b1);

        // R2 / R3 row layout
        build_rows();
        load(5892);
        sig_in = 22'h15_A5C3;
        tick();
        check("R2 enable rows 1 and 34", oe_out, 10'b00_0000_1001);
        check("R3 enable row not in sum", sum_out, 10'b10_0000_0000);
        check("R2 clear row 0 connected", ar_term, 1'b0);
        check("R2 set row 131 blown", sp_term, 1'b1);
        sig_in = 22'h2A_5A3C;
        tick();
        check("R2 layout with other inputs", {oe_out, sum_out}, {10'b00_0000_1001, 10'b10_0000_0000});

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule